// File: doc/BRIEF.md
# SD Host Normal Interrupt Status Logic

This block holds the 16-bit normal interrupt status word of an SD/eMMC host controller and raises one interrupt line from it. It watches levels and pulses coming from the rest of the controller and turns each into a status bit. Buffer and card-detect bits latch on level edges. Block gap and transfer complete latch on falling edges of the transfer-activity levels. Command complete, DMA boundary and boot acknowledge latch on single-cycle pulses. Software clears the latched bits by writing ones.

Two bits behave differently. The card interrupt bit tracks the card's interrupt input and ignores write-one-to-clear. It drops only when its status enable is removed. The error summary bit is a read-only OR of the external error status vector. A per-bit status-enable mask decides which events may latch. A per-bit signal-enable mask decides which latched bits reach the registered interrupt output.

Top module: `sdh_irq_status`

## Requirements
- R1: The status word has these bit positions: 15 error summary, 14 boot acknowledge, 8 card interrupt, 7 card removal, 6 card insertion, 5 buffer read ready, 4 buffer write ready, 3 DMA boundary, 2 block gap, 1 transfer complete, 0 command complete. Bits 13 to 9 always read 0, and after reset the word is 0x0000.
- R2: An event latches its status bit only while the matching `stat_en_i` bit is 1. With the enable at 0, the event leaves the bit at 0.
- R3: A write with `wr_en_i` high clears every latched bit among 14 and 7..0 whose `wr_data_i` bit is 1. Data bits at 0 leave their status bits unchanged. Bits 15 and 8 ignore writes.
- R4: When a set event and a write-one clear hit the same bit in the same cycle, the bit ends up set.
- R5: Bit 6 latches on a 0-to-1 change of `card_present_i`. Bit 7 latches on a 1-to-0 change of it.
- R6: Bit 5 latches on a rising edge of `rd_buf_en_i`. Bit 4 latches on a rising edge of `wr_buf_en_i`. A level that stays high does not latch them again.
- R7: Bit 2 latches only while `gap_stop_i` is 1. For a read (`dir_wr_i`=0) it latches on a falling edge of `dat_active_i`. For a write (`dir_wr_i`=1) it latches on a falling edge of `wr_xfer_active_i`.
- R8: Bit 1 latches on a falling edge of `rd_xfer_active_i` for a read. For a write or a command with busy (`dir_wr_i`=1) it latches on a falling edge of `dat_active_i`.
- R9: Bit 0 latches on a `cmd_end_i` pulse, but not when `cmd_auto_i` marks the response as one to an automatic stop or block-count command.
- R10: Bit 3 latches on a `dma_boundary_i` pulse. Bit 14 latches on a `boot_ack_i` pulse.
- R11: While `stat_en_i[8]` is 1, bit 8 is the value `card_irq_i` had one cycle earlier. Clearing `stat_en_i[8]` forces bit 8 to 0 on the next cycle.
- R12: Bit 15 equals the OR of all bits of `err_vec_i` in the same cycle and cannot be written.
- R13: `irq_o` is a register. It equals the OR of (status AND `sig_en_i`) from the previous cycle, so it falls one cycle after the last enabled bit clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| card_present_i | input | 1 | Card-inserted level |
| rd_buf_en_i | input | 1 | Buffer readable level |
| wr_buf_en_i | input | 1 | Buffer writable level |
| dat_active_i | input | 1 | Data-line-active level |
| rd_xfer_active_i | input | 1 | Read-transfer-active level |
| wr_xfer_active_i | input | 1 | Write-transfer-active level |
| dir_wr_i | input | 1 | 1 for write transfer or busy command, 0 for read |
| gap_stop_i | input | 1 | Stop-at-block-gap request |
| cmd_end_i | input | 1 | Pulse on response end bit |
| cmd_auto_i | input | 1 | Response belongs to an automatic command |
| dma_boundary_i | input | 1 | Pulse on DMA boundary or descriptor interrupt |
| boot_ack_i | input | 1 | Pulse on received boot acknowledge |
| card_irq_i | input | 1 | Card interrupt level |
| err_vec_i | input | ERR_W | Error status vector |
| wr_en_i | input | 1 | Status register write strobe |
| wr_data_i | input | 16 | Write data, 1 clears |
| stat_en_i | input | 16 | Per-bit status enable |
| sig_en_i | input | 16 | Per-bit interrupt signal enable |
| status_o | output | 16 | Status word |
| irq_o | output | 1 | Interrupt line |

## Verification
A lost edge register or a wrong edge polarity shows up as a status bit that stays 0, or that rises on the wrong transition, one cycle after the stimulus. A swapped read/write select moves block gap or transfer complete onto the wrong falling edge, and the bench exercises both directions. A clear path that wins over a simultaneous event, or that touches bits 8 or 15, is visible in the status word on the cycle after the write. An interrupt register that is missing or sits in the wrong place moves `irq_o` by one cycle relative to the status word. The bench therefore compares both at exact cycle offsets.

// File: rtl/sdh_irq_pkg.sv
package sdh_irq_pkg;
  localparam int STAT_W = 16;

  localparam int B_CMD  = 0;
  localparam int B_XFER = 1;
  localparam int B_GAP  = 2;
  localparam int B_DMA  = 3;
  localparam int B_WRDY = 4;
  localparam int B_RRDY = 5;
  localparam int B_INS  = 6;
  localparam int B_REM  = 7;
  localparam int B_CARD = 8;
  localparam int B_BOOT = 14;
  localparam int B_ERR  = 15;

  // bits that latch an event and clear on write-one
  localparam logic [STAT_W-1:0] W1C_MASK =
    (STAT_W'(1) << B_CMD)  | (STAT_W'(1) << B_XFER) | (STAT_W'(1) << B_GAP)  |
    (STAT_W'(1) << B_DMA)  | (STAT_W'(1) << B_WRDY) | (STAT_W'(1) << B_RRDY) |
    (STAT_W'(1) << B_INS)  | (STAT_W'(1) << B_REM)  | (STAT_W'(1) << B_BOOT);

  localparam logic [STAT_W-1:0] CARD_MASK = STAT_W'(1) << B_CARD;

  // levels watched for a rising edge
  typedef struct packed {
    logic card;
    logic rbuf;
    logic wbuf;
  } rise_lvl_t;

  // levels watched for a falling edge
  typedef struct packed {
    logic card;
    logic dat;
    logic rxf;
    logic wxf;
  } fall_lvl_t;
endpackage

// File: rtl/sdh_lvl_edge.sv
module sdh_lvl_edge #(
  parameter int  W    = 4,
  parameter bit  RISE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;

  always_comb prev_d = lvl_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  generate
    if (RISE) begin : g_rise
      always_comb edge_o = lvl_i & ~prev_q;
    end else begin : g_fall
      always_comb edge_o = ~lvl_i & prev_q;
    end
  endgenerate
endmodule

// File: rtl/sdh_evt_map.sv
module sdh_evt_map
  import sdh_irq_pkg::*;
(
  input  rise_lvl_t          rise_i,
  input  fall_lvl_t          fall_i,
  input  logic               dir_wr_i,
  input  logic               gap_stop_i,
  input  logic               cmd_end_i,
  input  logic               cmd_auto_i,
  input  logic               dma_i,
  input  logic               boot_i,
  output logic [STAT_W-1:0]  set_o
);
  always_comb begin
    set_o          = '0;
    set_o[B_INS]   = rise_i.card;
    set_o[B_REM]   = fall_i.card;
    set_o[B_RRDY]  = rise_i.rbuf;
    set_o[B_WRDY]  = rise_i.wbuf;
    set_o[B_DMA]   = dma_i;
    set_o[B_BOOT]  = boot_i;
    set_o[B_CMD]   = cmd_end_i & ~cmd_auto_i;
    // block gap: read ends at data-line idle, write at write-transfer idle
    set_o[B_GAP]   = gap_stop_i & (dir_wr_i ? fall_i.wxf : fall_i.dat);
    // transfer done: read at read-transfer idle, write/busy at data-line idle
    set_o[B_XFER]  = dir_wr_i ? fall_i.dat : fall_i.rxf;
  end
endmodule

// File: rtl/sdh_w1c_bit.sv
module sdh_w1c_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic en_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q;
  logic q_d;
  logic upd;
  logic set_ok;

  always_comb begin
    set_ok = set_i & en_i;
    upd    = set_ok | clr_i;
    q_d    = set_ok | (q_q & ~clr_i);   // a set beats a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q_q <= 1'b0;
    else if (upd) q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/sdh_irq_reduce.sv
module sdh_irq_reduce #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] sig_en_i,
  output logic         irq_o
);
  logic irq_q;
  logic irq_d;

  always_comb irq_d = |(status_i & sig_en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/sdh_irq_status.sv
module sdh_irq_status
  import sdh_irq_pkg::*;
#(
  parameter int ERR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              card_present_i,
  input  logic              rd_buf_en_i,
  input  logic              wr_buf_en_i,
  input  logic              dat_active_i,
  input  logic              rd_xfer_active_i,
  input  logic              wr_xfer_active_i,
  input  logic              dir_wr_i,
  input  logic              gap_stop_i,
  input  logic              cmd_end_i,
  input  logic              cmd_auto_i,
  input  logic              dma_boundary_i,
  input  logic              boot_ack_i,
  input  logic              card_irq_i,
  input  logic [ERR_W-1:0]  err_vec_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  input  logic [STAT_W-1:0] stat_en_i,
  input  logic [STAT_W-1:0] sig_en_i,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o
);
  localparam int RW = $bits(rise_lvl_t);
  localparam int FW = $bits(fall_lvl_t);

  // reset: asserted at once, released through two flops
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  rise_lvl_t rise_lvl, rise_evt;
  fall_lvl_t fall_lvl, fall_evt;
  logic [RW-1:0] rise_edge;
  logic [FW-1:0] fall_edge;
  logic [STAT_W-1:0] set_evt;
  logic [STAT_W-1:0] clr_req;

  always_comb begin
    rise_lvl.card = card_present_i;
    rise_lvl.rbuf = rd_buf_en_i;
    rise_lvl.wbuf = wr_buf_en_i;
    fall_lvl.card = card_present_i;
    fall_lvl.dat  = dat_active_i;
    fall_lvl.rxf  = rd_xfer_active_i;
    fall_lvl.wxf  = wr_xfer_active_i;
    rise_evt      = rise_lvl_t'(rise_edge);
    fall_evt      = fall_lvl_t'(fall_edge);
    clr_req       = wr_en_i ? wr_data_i : '0;
  end

  sdh_lvl_edge #(.W(RW), .RISE(1'b1)) u_rise (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .lvl_i  (RW'(rise_lvl)),
    .edge_o (rise_edge)
  );

  sdh_lvl_edge #(.W(FW), .RISE(1'b0)) u_fall (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .lvl_i  (FW'(fall_lvl)),
    .edge_o (fall_edge)
  );

  sdh_evt_map u_map (
    .rise_i     (rise_evt),
    .fall_i     (fall_evt),
    .dir_wr_i   (dir_wr_i),
    .gap_stop_i (gap_stop_i),
    .cmd_end_i  (cmd_end_i),
    .cmd_auto_i (cmd_auto_i),
    .dma_i      (dma_boundary_i),
    .boot_i     (boot_ack_i),
    .set_o      (set_evt)
  );

  generate
    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
      if (W1C_MASK[b]) begin : g_w1c
        sdh_w1c_bit u_bit (
          .clk   (clk),
          .rst_n (rst_sync_n),
          .set_i (set_evt[b]),
          .en_i  (stat_en_i[b]),
          .clr_i (clr_req[b]),
          .q_o   (status_o[b])
        );
      end else if (b == B_CARD) begin : g_card
        logic card_q;
        logic card_d;
        always_comb card_d = stat_en_i[b] & card_irq_i;
        always_ff @(posedge clk or negedge rst_sync_n) begin
          if (!rst_sync_n) card_q <= 1'b0;
          else             card_q <= card_d;
        end
        assign status_o[b] = card_q;
      end else if (b == B_ERR) begin : g_err
        assign status_o[b] = |err_vec_i;
      end else begin : g_rsvd
        assign status_o[b] = 1'b0;
      end
    end
  endgenerate

  sdh_irq_reduce #(.W(STAT_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .status_i (status_o),
    .sig_en_i (sig_en_i),
    .irq_o    (irq_o)
  );

  // bits of the masks and write data that no status bit consumes
  logic unused_bits;
  assign unused_bits = ^{clr_req & ~W1C_MASK, stat_en_i & ~(W1C_MASK | CARD_MASK),
                         set_evt & ~W1C_MASK};
endmodule

// File: rtl/sdh_irq_status_chk.sv
module sdh_irq_status_chk
  import sdh_irq_pkg::*;
#(
  parameter int ERR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] status_o,
  input  logic              irq_o,
  input  logic [STAT_W-1:0] stat_en_i,
  input  logic [STAT_W-1:0] sig_en_i,
  input  logic              wr_en_i,
  input  logic [STAT_W-1:0] wr_data_i,
  input  logic [ERR_W-1:0]  err_vec_i,
  input  logic              card_irq_i,
  input  logic              cmd_end_i,
  input  logic              dma_boundary_i
);
  logic unused_chk;
  assign unused_chk = ^{wr_data_i, stat_en_i};

  always_comb begin
    if (rst_n) begin
      assert_rsvd_zero_R1: assert (status_o[13:9] == 5'b0);
      assert_err_or_R12:   assert (status_o[B_ERR] == |err_vec_i);
    end
  end

  generate
    for (genvar k = 0; k < STAT_W; k++) begin : g_gate
      if (W1C_MASK[k]) begin : g_on
        assert_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
          !stat_en_i[k] |=> !$rose(status_o[k]));
      end
    end
  endgenerate

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_end_i && !(wr_en_i && wr_data_i[B_CMD])) |=> $stable(status_o[B_CMD]));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i[B_DMA] && !dma_boundary_i) |=> !status_o[B_DMA]);

  assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_boundary_i && stat_en_i[B_DMA]) |=> status_o[B_DMA]);

  assert_card_follow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stat_en_i[B_CARD] |=> (status_o[B_CARD] == $past(card_irq_i)));

  assert_card_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_en_i[B_CARD] |=> !status_o[B_CARD]);

  assert_irq_reg_R13: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(|(status_o & sig_en_i))));
endmodule

bind sdh_irq_status sdh_irq_status_chk #(.ERR_W(ERR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .status_o       (status_o),
  .irq_o          (irq_o),
  .stat_en_i      (stat_en_i),
  .sig_en_i       (sig_en_i),
  .wr_en_i        (wr_en_i),
  .wr_data_i      (wr_data_i),
  .err_vec_i      (err_vec_i),
  .card_irq_i     (card_irq_i),
  .cmd_end_i      (cmd_end_i),
  .dma_boundary_i (dma_boundary_i)
);

// File: tb/sim_sdh_irq_status.sv
module sim_sdh_irq_status;
  localparam int EW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic card_present = 0, rd_buf = 0, wr_buf = 0, dat_act = 0, rd_xf = 0, wr_xf = 0;
  logic dir_wr = 0, gap_stop = 0, cmd_end = 0, cmd_auto = 0, dma = 0, boot = 0, card_irq = 0;
  logic [EW-1:0] err_vec = '0;
  logic          wr_en = 0;
  logic [15:0]   wr_data = '0;
  logic [15:0]   stat_en = 16'hFFFF;
  logic [15:0]   sig_en = 16'h0000;
  logic [15:0]   status;
  logic          irq;

  always #4 clk = ~clk;

  sdh_irq_status #(.ERR_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .card_present_i(card_present), .rd_buf_en_i(rd_buf),
    .wr_buf_en_i(wr_buf), .dat_active_i(dat_act), .rd_xfer_active_i(rd_xf),
    .wr_xfer_active_i(wr_xf), .dir_wr_i(dir_wr), .gap_stop_i(gap_stop),
    .cmd_end_i(cmd_end), .cmd_auto_i(cmd_auto), .dma_boundary_i(dma),
    .boot_ack_i(boot), .card_irq_i(card_irq), .err_vec_i(err_vec),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .stat_en_i(stat_en),
    .sig_en_i(sig_en), .status_o(status), .irq_o(irq)
  );

  typedef struct {
    int          due;
    logic [15:0] mask;
    logic [15:0] val;
    bit          is_irq;
    string       tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare every expected item that falls due this cycle
  always @(posedge clk) begin
    #2;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due == cyc) begin
        checks++;
        if (q[i].is_irq) begin
          if (irq !== q[i].val[0]) begin
            errors++;
            $display("FAIL %s irq actual %0b expected %0b", q[i].tag, irq, q[i].val[0]);
          end
        end else if ((status & q[i].mask) !== q[i].val) begin
          errors++;
          $display("FAIL %s status actual %h expected %h (mask %h)",
                   q[i].tag, status & q[i].mask, q[i].val, q[i].mask);
        end
        q.delete(i);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic exp_st(int dly, logic [15:0] mask, logic [15:0] val, string tag);
    q.push_back('{cyc + dly, mask, val, 1'b0, tag});
  endtask

  task automatic exp_irq(int dly, logic val, string tag);
    q.push_back('{cyc + dly, 16'h0001, {15'b0, val}, 1'b1, tag});
  endtask

  task automatic wr_clr(logic [15:0] d);
    wr_en = 1'b1; wr_data = d;
  endtask

  task automatic wr_off();
    wr_en = 1'b0; wr_data = '0;
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    exp_st(1, 16'hFFFF, 16'h0000, "R1 reset word");
    exp_irq(1, 1'b0, "R13 reset irq");
    tick();

    // R5 card insertion and removal
    card_present = 1; exp_st(1, 16'h00C0, 16'h0040, "R5 insert"); tick();
    wr_clr(16'h0040); exp_st(1, 16'h00C0, 16'h0000, "R3 clear insert"); tick();
    wr_off(); exp_st(1, 16'h00C0, 16'h0000, "R5 steady high"); tick();
    card_present = 0; exp_st(1, 16'h00C0, 16'h0080, "R5 removal"); tick();
    wr_clr(16'hFFFF); exp_st(1, 16'h40FF, 16'h0000, "R3 clear all"); tick();
    wr_off();

    // R6 buffer ready edges
    rd_buf = 1; exp_st(1, 16'h0030, 16'h0020, "R6 read ready"); tick();
    wr_buf = 1; exp_st(1, 16'h0030, 16'h0030, "R6 write ready"); tick();
    wr_clr(16'h0030); exp_st(1, 16'h0030, 16'h0000, "R3 clear buffers"); tick();
    wr_off(); exp_st(1, 16'h0030, 16'h0000, "R6 level no relatch"); tick();
    rd_buf = 0; wr_buf = 0; tick();

    // R10 DMA, R3 write-zero, R4 set beats clear
    dma = 1; exp_st(1, 16'h0008, 16'h0008, "R10 dma"); tick();
    dma = 0; wr_clr(16'h0000); exp_st(1, 16'h0008, 16'h0008, "R3 write zero"); tick();
    dma = 1; wr_clr(16'h0008); exp_st(1, 16'h0008, 16'h0008, "R4 set wins"); tick();
    dma = 0; exp_st(1, 16'h0008, 16'h0000, "R3 clear dma"); tick();
    wr_off();

    // R2 status enable, R10 boot ack
    stat_en[14] = 0; boot = 1; exp_st(1, 16'h4000, 16'h0000, "R2 boot masked"); tick();
    stat_en[14] = 1; exp_st(1, 16'h4000, 16'h4000, "R10 boot ack"); tick();
    boot = 0; wr_clr(16'h4000); exp_st(1, 16'h4000, 16'h0000, "R3 clear boot"); tick();
    wr_off();

    // R9 command complete
    cmd_end = 1; cmd_auto = 1; exp_st(1, 16'h0001, 16'h0000, "R9 auto response"); tick();
    cmd_auto = 0; exp_st(1, 16'h0001, 16'h0001, "R9 cmd complete"); tick();
    cmd_end = 0; wr_clr(16'h0001); tick();
    wr_off();

    // R7 R8 read direction
    dir_wr = 0; gap_stop = 1; dat_act = 1; rd_xf = 1; tick();
    dat_act = 0; exp_st(1, 16'h0006, 16'h0004, "R7 read gap"); tick();
    rd_xf = 0; exp_st(1, 16'h0006, 16'h0006, "R8 read done"); tick();
    wr_clr(16'h0006); tick();
    wr_off(); gap_stop = 0; dat_act = 1; tick();
    dat_act = 0; exp_st(1, 16'h0006, 16'h0000, "R7 no stop request"); tick();

    // R7 R8 write direction
    dir_wr = 1; gap_stop = 1; dat_act = 1; wr_xf = 1; tick();
    wr_xf = 0; exp_st(1, 16'h0006, 16'h0004, "R7 write gap"); tick();
    dat_act = 0; exp_st(1, 16'h0006, 16'h0006, "R8 write done"); tick();
    wr_clr(16'h0006); gap_stop = 0; tick();
    wr_off();

    // R11 card interrupt
    card_irq = 1; exp_st(1, 16'h0100, 16'h0100, "R11 follow"); tick();
    wr_clr(16'h0100); exp_st(1, 16'h0100, 16'h0100, "R3 card ignores write"); tick();
    wr_off(); stat_en[8] = 0; exp_st(1, 16'h0100, 16'h0000, "R11 enable drop"); tick();
    stat_en[8] = 1; card_irq = 0; exp_st(1, 16'h0100, 16'h0000, "R11 input low"); tick();

    // R12 error summary
    err_vec = 16'h0004; exp_st(1, 16'h8000, 16'h8000, "R12 error or"); tick();
    wr_clr(16'h8000); exp_st(1, 16'h8000, 16'h8000, "R12 read only"); tick();
    wr_off(); err_vec = '0; exp_st(1, 16'h8000, 16'h0000, "R12 error gone"); tick();

    // R13 interrupt timing and masking
    sig_en = 16'h0008; dma = 1;
    exp_st(1, 16'h0008, 16'h0008, "R13 status first");
    exp_irq(1, 1'b0, "R13 irq lags"); exp_irq(2, 1'b1, "R13 irq rises"); tick();
    dma = 0; wr_clr(16'h0008);
    exp_irq(1, 1'b1, "R13 irq holds"); exp_irq(2, 1'b0, "R13 irq falls"); tick();
    wr_off(); sig_en = 16'h0000; tick();
    dma = 1; exp_irq(2, 1'b0, "R13 masked"); tick();
    dma = 0; wr_clr(16'h0008); tick();
    wr_off();

    repeat (4) tick();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule